// File: doc/BRIEF.md
# Two-Way Set-Associative Data Cache with Selectable Store Policy

This block sits between a processor load/store port and a line-wide memory port. Each 32-bit word address is split into a tag, a set index and a byte offset. Both ways of the indexed set are looked up in the same cycle, and a match on a valid entry is a hit. A load that hits returns its word one cycle after it is accepted. A miss stalls the processor port while the memory handshake runs. It first writes back a dirty victim, then fetches the naturally aligned line. After that the access is replayed against the refilled line.

Two elaboration-time parameters set the store policy, and each can be chosen without the other. `WRITE_BACK` picks between marking a line dirty on a store hit and forwarding every store to memory at once. `WRITE_ALLOC` picks between fetching the line on a store miss and sending the store straight to memory without touching the cache. Each set holds one recency bit. An empty way is always filled before that bit is consulted.

With the defaults (64 sets, 16-byte lines) the address splits into a 22-bit tag, a 6-bit index and a 4-bit offset. Setting `INDEX_W` to 10 gives a 32 KB, 1024-set arrangement with an 18-bit tag.

Top module: `wc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high, and `cpu_rvalid` and `mem_req` are low.
- R2: A load miss issues exactly one memory read. Its `mem_addr` is the line base (address with bits [3:0] zero). The load returns the word selected by address bits [3:2], where word w occupies bits [32w+31:32w] of the line.
- R3: A load hit raises `cpu_rvalid` with the data in the cycle after acceptance and causes no memory request.
- R4: Two lines with equal index and different tags are held at the same time, one per way. An invalid way is filled before any valid way is replaced.
- R5: When both ways are valid, a miss replaces the way that was not used most recently.
- R6: With `WRITE_BACK`=1, a store hit updates only the bytes whose `cpu_be` bit is set, in the cached line. It completes in one cycle and does not write memory.
- R7: With `WRITE_BACK`=1, a miss whose victim is dirty first writes the whole victim line to the victim's base address, and only then reads the new line.
- R8: A miss whose victim is clean, or any miss with `WRITE_BACK`=0, issues no memory write.
- R9: With `WRITE_ALLOC`=1, a store miss reads the line, merges the store into it, and later loads of that line hit.
- R10: With `WRITE_BACK`=0, a store hit updates the cached line and also writes memory. The write uses `mem_be` bits [4w+3:4w] set from `cpu_be` for word w, and all other mask bits are clear.
- R11: With `WRITE_ALLOC`=0, a store miss writes memory under the byte mask and leaves the cache unchanged, so a following load of that line misses.
- R12: `cpu_ready` is low whenever a memory request is outstanding. The request holds its address and direction until `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, taken when `cpu_ready` is high |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Word-aligned byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte mask |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory request, held until `mem_done` |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wdata | output | 128 | Line write data |
| mem_be | output | 16 | Byte mask for memory writes |
| mem_rdata | input | 128 | Line read data, valid with `mem_done` |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a dirty victim chosen by the recency bit. To get there, one set must be filled in both ways with a dirty line in the older way, and the stimulus must be ordered so the recency bit points at that dirty line. The bench does this with a sequence of accesses to one set: an allocating store, a partial store hit, a load that fills the second way, and then a third tag. It reads the memory model's operation log to confirm that the full-line write comes before the read. A second instance, built for forwarding stores without allocation, shows that the same stimulus patterns produce masked word writes and no evictions to memory.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int WAYS   = 2;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_EVICT  = 3'd1,
    ST_FILL   = 3'd2,
    ST_REPLAY = 3'd3,
    ST_WRMEM  = 3'd4
  } wc_state_t;
endpackage

// File: rtl/wc_rst_sync.sv
module wc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wc_tag_store.sv
module wc_tag_store #(
  parameter int INDEX_W = 6,
  parameter int TAG_W   = 22
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [INDEX_W-1:0]     idx,
  output logic [1:0]             valid_o,
  output logic [1:0]             dirty_o,
  output logic [1:0][TAG_W-1:0]  tag_o,
  output logic                   lru_o,
  input  logic                   fill_en,
  input  logic                   fill_way,
  input  logic [TAG_W-1:0]       fill_tag,
  input  logic                   dirty_en,
  input  logic                   dirty_way,
  input  logic                   lru_en,
  input  logic                   lru_val
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lru_q <= '0;
    else if (lru_en) lru_q[idx] <= lru_val;
  end
  assign lru_o = lru_q[idx];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic             fill_sel;
    logic             mark_sel;

    assign fill_sel = fill_en && (fill_way == 1'(w));
    assign mark_sel = dirty_en && (dirty_way == 1'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= '0;
        dirty_q <= '0;
      end else if (fill_sel) begin
        valid_q[idx] <= 1'b1;
        dirty_q[idx] <= 1'b0;
      end else if (mark_sel) begin
        dirty_q[idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_sel) tag_q[idx] <= fill_tag;
    end

    assign valid_o[w] = valid_q[idx];
    assign dirty_o[w] = dirty_q[idx];
    assign tag_o[w]   = tag_q[idx];
  end

  assert_fill_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !dirty_en);
endmodule

// File: rtl/wc_data_store.sv
module wc_data_store #(
  parameter int INDEX_W = 6,
  parameter int LINE_W  = 128,
  parameter int WSEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INDEX_W-1:0]      idx,
  output logic [1:0][LINE_W-1:0]  line_o,
  input  logic                    fill_en,
  input  logic                    fill_way,
  input  logic [LINE_W-1:0]       fill_line,
  input  logic                    wr_en,
  input  logic                    wr_way,
  input  logic [WSEL_W-1:0]       wr_word,
  input  logic [3:0]              wr_be,
  input  logic [31:0]             wr_data
);
  localparam int SETS = 1 << INDEX_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];
    logic [LINE_W-1:0] merged;
    logic              fill_sel;
    logic              wr_sel;

    assign fill_sel = fill_en && (fill_way == 1'(w));
    assign wr_sel   = wr_en && (wr_way == 1'(w));

    always_comb begin
      merged = line_q[idx];
      for (int b = 0; b < 4; b++) begin
        if (wr_be[b]) merged[{wr_word, 5'd0} + b*8 +: 8] = wr_data[b*8 +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (fill_sel)    line_q[idx] <= fill_line;
      else if (wr_sel) line_q[idx] <= merged;
    end

    assign line_o[w] = line_q[idx];
  end

  assert_no_fill_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && wr_en));
endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int INDEX_W     = 6,
  parameter int OFF_W       = 4,
  parameter int TAG_W       = 22,
  parameter int LINE_W      = 128,
  parameter int LINE_BYTES  = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [WORD_W-1:0]       cpu_wdata,
  input  logic [3:0]              cpu_be,
  output logic                    cpu_ready,
  output logic                    cpu_rvalid,
  output logic [WORD_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LINE_W-1:0]       mem_wdata,
  output logic [LINE_BYTES-1:0]   mem_be,
  input  logic [LINE_W-1:0]       mem_rdata,
  input  logic                    mem_done,
  output logic [INDEX_W-1:0]      idx,
  input  logic [1:0]              valid_i,
  input  logic [1:0]              dirty_i,
  input  logic [1:0][TAG_W-1:0]   tag_i,
  input  logic                    lru_i,
  input  logic [1:0][LINE_W-1:0]  line_i,
  output logic                    tfill_en,
  output logic                    fill_way,
  output logic [TAG_W-1:0]        fill_tag,
  output logic                    dirty_en,
  output logic                    lru_en,
  output logic                    lru_val,
  output logic                    wr_en,
  output logic                    wr_way,
  output logic [OFF_W-3:0]        wr_word
);
  localparam int WSEL_W = OFF_W - 2;
  localparam int WORDS  = LINE_W / WORD_W;

  wc_state_t          state_q, state_d;
  logic [ADDR_W-1:0]  addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [3:0]         be_q;
  logic               we_q;
  logic               vic_q;
  logic               rvalid_q;
  logic [WORD_W-1:0]  rdata_q;

  logic [ADDR_W-1:0]  a_addr;
  logic               a_we;
  logic               act;
  logic [TAG_W-1:0]   a_tag;
  logic [1:0]         hit_w;
  logic               hit;
  logic               hit_way;
  logic               victim;
  logic               latch_en;
  logic               rd_fire;
  logic [WORD_W-1:0]  rd_word;

  // Address selection: live port in idle, held request otherwise
  assign a_addr  = (state_q == ST_IDLE) ? cpu_addr : addr_q;
  assign a_we    = (state_q == ST_IDLE) ? cpu_we   : we_q;
  assign act     = ((state_q == ST_IDLE) && cpu_req) || (state_q == ST_REPLAY);
  assign a_tag   = a_addr[ADDR_W-1 -: TAG_W];
  assign idx     = a_addr[OFF_W +: INDEX_W];
  assign wr_word = a_addr[2 +: WSEL_W];

  // Parallel tag compare of both ways
  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = valid_i[w] && (tag_i[w] == a_tag);
  end
  assign hit     = |hit_w;
  assign hit_way = hit_w[1];
  assign victim  = !valid_i[0] ? 1'b0 : (!valid_i[1] ? 1'b1 : lru_i);
  assign rd_word = line_i[hit_way][{wr_word, 5'd0} +: WORD_W];

  // Array update strobes
  always_comb begin
    wr_en    = act && hit && a_we;
    wr_way   = hit_way;
    dirty_en = wr_en && WRITE_BACK;
    tfill_en = (state_q == ST_FILL) && mem_done;
    fill_way = vic_q;
    fill_tag = a_tag;
    lru_en   = (act && hit) || tfill_en;
    lru_val  = tfill_en ? !vic_q : !hit_way;
    rd_fire  = act && hit && !a_we;
  end

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    latch_en = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          latch_en = 1'b1;
          if (hit) begin
            if (cpu_we && !WRITE_BACK) state_d = ST_WRMEM;
          end else if (cpu_we && !WRITE_ALLOC) begin
            state_d = ST_WRMEM;
          end else if (WRITE_BACK && valid_i[victim] && dirty_i[victim]) begin
            state_d = ST_EVICT;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_EVICT:  if (mem_done) state_d = ST_FILL;
      ST_FILL:   if (mem_done) state_d = ST_REPLAY;
      ST_REPLAY: state_d = (we_q && !WRITE_BACK) ? ST_WRMEM : ST_IDLE;
      ST_WRMEM:  if (mem_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Memory request drive
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    mem_wdata = line_i[vic_q];
    mem_be    = '1;
    case (state_q)
      ST_EVICT: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tag_i[vic_q], idx, {OFF_W{1'b0}}};
      end
      ST_FILL: begin
        mem_req = 1'b1;
        mem_be  = '0;
      end
      ST_WRMEM: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {WORDS{wdata_q}};
        mem_be    = {{(LINE_BYTES-4){1'b0}}, be_q} << {wr_word, 2'b00};
      end
      default: ;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      vic_q   <= 1'b0;
    end else if (latch_en) begin
      addr_q  <= cpu_addr;
      wdata_q <= cpu_wdata;
      be_q    <= cpu_be;
      we_q    <= cpu_we;
      vic_q   <= victim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_word;
  end

  assign cpu_ready  = (state_q == ST_IDLE);
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  // Checks placed beside the controller
  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready) |-> (cpu_addr[1:0] == 2'b00));
  assert_replay_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REPLAY) |-> hit);
  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);
  assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_evict_then_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVICT && mem_done) |=> (mem_req && !mem_we));
  assert_full_write_wb_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && (&mem_be)) |-> WRITE_BACK);
endmodule

// File: rtl/wc_cache.sv
module wc_cache #(
  parameter int INDEX_W     = 6,
  parameter int LINE_BYTES  = 16,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [31:0]             cpu_addr,
  input  logic [31:0]             cpu_wdata,
  input  logic [3:0]              cpu_be,
  output logic                    cpu_ready,
  output logic                    cpu_rvalid,
  output logic [31:0]             cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [31:0]             mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  output logic [LINE_BYTES-1:0]   mem_be,
  input  logic [LINE_BYTES*8-1:0] mem_rdata,
  input  logic                    mem_done
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int TAG_W  = 32 - INDEX_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int WSEL_W = OFF_W - 2;

  logic                   rst_q_n;
  logic [INDEX_W-1:0]     idx;
  logic [1:0]             valid;
  logic [1:0]             dirty;
  logic [1:0][TAG_W-1:0]  tags;
  logic                   lru;
  logic [1:0][LINE_W-1:0] lines;
  logic                   fill_en;
  logic                   fill_way;
  logic [TAG_W-1:0]       fill_tag;
  logic                   dirty_en;
  logic                   lru_en;
  logic                   lru_val;
  logic                   wr_en;
  logic                   wr_way;
  logic [WSEL_W-1:0]      wr_word;

  wc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  wc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_q_n), .idx(idx),
    .valid_o(valid), .dirty_o(dirty), .tag_o(tags), .lru_o(lru),
    .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .dirty_way(wr_way),
    .lru_en(lru_en), .lru_val(lru_val)
  );

  wc_data_store #(.INDEX_W(INDEX_W), .LINE_W(LINE_W), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .rst_n(rst_q_n), .idx(idx), .line_o(lines),
    .fill_en(fill_en), .fill_way(fill_way), .fill_line(mem_rdata),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word),
    .wr_be(cpu_req && cpu_ready ? cpu_be : u_ctrl.be_q),
    .wr_data(cpu_req && cpu_ready ? cpu_wdata : u_ctrl.wdata_q)
  );

  wc_ctrl #(
    .INDEX_W(INDEX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
    .LINE_BYTES(LINE_BYTES), .WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_done(mem_done),
    .idx(idx), .valid_i(valid), .dirty_i(dirty), .tag_i(tags), .lru_i(lru),
    .line_i(lines),
    .tfill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
    .dirty_en(dirty_en), .lru_en(lru_en), .lru_val(lru_val),
    .wr_en(wr_en), .wr_way(wr_way), .wr_word(wr_word)
  );
endmodule

// File: tb/sim_wc_cache.sv
module sim_mem (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         we,
  input  logic [31:0]  addr,
  input  logic [127:0] wdata,
  input  logic [15:0]  be,
  output logic [127:0] rdata,
  output logic         done
);
  logic [127:0] mem [256];
  int           n_rd = 0;
  int           n_wr = 0;
  int           n_ops = 0;
  logic [31:0]  log_addr [64];
  logic         log_we [64];
  logic [15:0]  last_be = '0;
  int           cnt;

  initial begin
    for (int i = 0; i < 256; i++)
      for (int w = 0; w < 4; w++)
        mem[i][w*32 +: 32] = 32'h5A000000 | ((i * 16 + w * 4) & 32'h00FFFFFC);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      cnt   <= 0;
      rdata <= '0;
    end else if (done) begin
      done <= 1'b0;
      cnt  <= 0;
    end else if (req) begin
      if (cnt == 2) begin
        done <= 1'b1;
        if (n_ops < 64) begin
          log_addr[n_ops] <= addr;
          log_we[n_ops]   <= we;
        end
        n_ops <= n_ops + 1;
        if (we) begin
          for (int b = 0; b < 16; b++)
            if (be[b]) mem[addr[11:4]][b*8 +: 8] <= wdata[b*8 +: 8];
          n_wr    <= n_wr + 1;
          last_be <= be;
        end else begin
          rdata <= mem[addr[11:4]];
          n_rd  <= n_rd + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module sim_wc_cache;
  logic clk;
  logic rst_n;

  logic         c_req [2];
  logic         c_we [2];
  logic [31:0]  c_addr [2];
  logic [31:0]  c_wd [2];
  logic [3:0]   c_be [2];
  logic         c_ready [2];
  logic         c_rvalid [2];
  logic [31:0]  c_rdata [2];
  logic         m_req [2];
  logic         m_we [2];
  logic [31:0]  m_addr [2];
  logic [127:0] m_wdata [2];
  logic [15:0]  m_be [2];
  logic [127:0] m_rdata [2];
  logic         m_done [2];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  wc_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[0]), .cpu_we(c_we[0]), .cpu_addr(c_addr[0]),
    .cpu_wdata(c_wd[0]), .cpu_be(c_be[0]),
    .cpu_ready(c_ready[0]), .cpu_rvalid(c_rvalid[0]), .cpu_rdata(c_rdata[0]),
    .mem_req(m_req[0]), .mem_we(m_we[0]), .mem_addr(m_addr[0]),
    .mem_wdata(m_wdata[0]), .mem_be(m_be[0]), .mem_rdata(m_rdata[0]),
    .mem_done(m_done[0])
  );

  wc_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(c_req[1]), .cpu_we(c_we[1]), .cpu_addr(c_addr[1]),
    .cpu_wdata(c_wd[1]), .cpu_be(c_be[1]),
    .cpu_ready(c_ready[1]), .cpu_rvalid(c_rvalid[1]), .cpu_rdata(c_rdata[1]),
    .mem_req(m_req[1]), .mem_we(m_we[1]), .mem_addr(m_addr[1]),
    .mem_wdata(m_wdata[1]), .mem_be(m_be[1]), .mem_rdata(m_rdata[1]),
    .mem_done(m_done[1])
  );

  sim_mem u_mem0 (.clk(clk), .rst_n(rst_n), .req(m_req[0]), .we(m_we[0]),
    .addr(m_addr[0]), .wdata(m_wdata[0]), .be(m_be[0]),
    .rdata(m_rdata[0]), .done(m_done[0]));
  sim_mem u_mem1 (.clk(clk), .rst_n(rst_n), .req(m_req[1]), .we(m_we[1]),
    .addr(m_addr[1]), .wdata(m_wdata[1]), .be(m_be[1]),
    .rdata(m_rdata[1]), .done(m_done[1]));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'h5A000000 | (a & 32'h00FFFFFC);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input int d, input bit we, input logic [31:0] a,
                        input logic [31:0] wd, input logic [3:0] be,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!c_ready[d]) @(negedge clk);
    c_req[d] = 1'b1; c_we[d] = we; c_addr[d] = a; c_wd[d] = wd; c_be[d] = be;
    @(negedge clk);
    lat = 1;
    c_req[d] = 1'b0;
    rd = '0;
    if (!we) begin
      while (!c_rvalid[d]) begin @(negedge clk); lat++; end
      rd = c_rdata[d];
    end else begin
      while (!c_ready[d]) begin @(negedge clk); lat++; end
    end
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      chk(c_ready[d] === 1'b1, "R1 ready", 32'(c_ready[d]), 1);
      chk(c_rvalid[d] === 1'b0, "R1 rvalid", 32'(c_rvalid[d]), 0);
      chk(m_req[d] === 1'b0, "R1 mem_req", 32'(m_req[d]), 0);
    end
  endtask

  task automatic t_load_miss_hit();
    logic [31:0] rd; int lat; int r0; int n0;
    r0 = u_mem0.n_rd; n0 = u_mem0.n_ops;
    access(0, 0, 32'h018, 0, 0, rd, lat);
    chk(rd == pat(32'h018), "R2 miss data", rd, pat(32'h018));
    chk(u_mem0.n_rd == r0 + 1, "R2 one read", u_mem0.n_rd, r0 + 1);
    chk(u_mem0.log_addr[n0] == 32'h010, "R2 line base", u_mem0.log_addr[n0], 32'h010);
    chk(lat > 1, "R12 miss stalls", lat, 2);
    access(0, 0, 32'h01C, 0, 0, rd, lat);
    chk(rd == pat(32'h01C), "R3 hit data", rd, pat(32'h01C));
    chk(lat == 1, "R3 hit latency", lat, 1);
    chk(u_mem0.n_rd == r0 + 1, "R3 no traffic", u_mem0.n_rd, r0 + 1);
  endtask

  task automatic t_lru();
    logic [31:0] rd; int lat; int w0;
    w0 = u_mem0.n_wr;
    access(0, 0, 32'h410, 0, 0, rd, lat);
    chk(rd == pat(32'h410), "R4 second way data", rd, pat(32'h410));
    access(0, 0, 32'h014, 0, 0, rd, lat);
    chk(lat == 1, "R4 first way kept", lat, 1);
    access(0, 0, 32'h414, 0, 0, rd, lat);
    chk(lat == 1, "R4 second way kept", lat, 1);
    access(0, 0, 32'h010, 0, 0, rd, lat);
    access(0, 0, 32'h810, 0, 0, rd, lat);
    chk(rd == pat(32'h810), "R5 third tag data", rd, pat(32'h810));
    chk(u_mem0.n_wr == w0, "R8 clean victim no write", u_mem0.n_wr, w0);
    access(0, 0, 32'h018, 0, 0, rd, lat);
    chk(lat == 1, "R5 recent way kept", lat, 1);
    access(0, 0, 32'h418, 0, 0, rd, lat);
    chk(lat > 1, "R5 older way evicted", lat, 2);
  endtask

  task automatic t_write_back();
    logic [31:0] rd; int lat; int r0; int w0; int n0; logic [31:0] exp;
    r0 = u_mem0.n_rd; w0 = u_mem0.n_wr;
    access(0, 1, 32'h024, 32'h11223344, 4'hF, rd, lat);
    chk(u_mem0.n_rd == r0 + 1, "R9 allocate read", u_mem0.n_rd, r0 + 1);
    chk(lat > 1, "R9 store miss stalls", lat, 2);
    access(0, 0, 32'h024, 0, 0, rd, lat);
    chk(rd == 32'h11223344 && lat == 1, "R9 merged and hit", rd, 32'h11223344);
    access(0, 1, 32'h028, 32'hAABB0000, 4'b1100, rd, lat);
    chk(lat == 1, "R6 store hit one cycle", lat, 1);
    access(0, 0, 32'h028, 0, 0, rd, lat);
    exp = {16'hAABB, pat(32'h028) >> 16 == 0 ? 16'h0 : pat(32'h028)[15:0]};
    chk(rd == exp, "R6 byte merge", rd, exp);
    chk(u_mem0.n_wr == w0, "R6 memory untouched", u_mem0.n_wr, w0);
    chk(u_mem0.mem[2][63:32] == pat(32'h024), "R6 memory stale", u_mem0.mem[2][63:32], pat(32'h024));
    access(0, 0, 32'h420, 0, 0, rd, lat);
    n0 = u_mem0.n_ops;
    access(0, 0, 32'h820, 0, 0, rd, lat);
    chk(u_mem0.log_we[n0] == 1'b1 && u_mem0.log_addr[n0] == 32'h020,
        "R7 writeback first", u_mem0.log_addr[n0], 32'h020);
    chk(u_mem0.log_we[n0+1] == 1'b0 && u_mem0.log_addr[n0+1] == 32'h820,
        "R7 refill second", u_mem0.log_addr[n0+1], 32'h820);
    chk(u_mem0.mem[2][63:32] == 32'h11223344, "R7 victim word1", u_mem0.mem[2][63:32], 32'h11223344);
    chk(u_mem0.mem[2][95:64] == exp, "R7 victim word2", u_mem0.mem[2][95:64], exp);
    chk(rd == pat(32'h820), "R7 new line data", rd, pat(32'h820));
  endtask

  task automatic t_write_through();
    logic [31:0] rd; int lat; int w0; logic [31:0] exp;
    access(1, 0, 32'h030, 0, 0, rd, lat);
    w0 = u_mem1.n_wr;
    access(1, 1, 32'h034, 32'h0000BEEF, 4'b0011, rd, lat);
    exp = {pat(32'h034)[31:16], 16'hBEEF};
    chk(lat > 1, "R12 forwarded store stalls", lat, 2);
    chk(u_mem1.n_wr == w0 + 1, "R10 memory written", u_mem1.n_wr, w0 + 1);
    chk(u_mem1.last_be == 16'h0030, "R10 lane mask", 32'(u_mem1.last_be), 32'h30);
    chk(u_mem1.mem[3][63:32] == exp, "R10 memory data", u_mem1.mem[3][63:32], exp);
    access(1, 0, 32'h034, 0, 0, rd, lat);
    chk(rd == exp && lat == 1, "R10 cache updated", rd, exp);
    access(1, 1, 32'h438, 32'hCAFEF00D, 4'hF, rd, lat);
    chk(u_mem1.mem[67][95:64] == 32'hCAFEF00D, "R11 around memory", u_mem1.mem[67][95:64], 32'hCAFEF00D);
    chk(u_mem1.last_be == 16'h0F00, "R11 lane mask", 32'(u_mem1.last_be), 32'hF00);
    access(1, 0, 32'h438, 0, 0, rd, lat);
    chk(lat > 1, "R11 cache not allocated", lat, 2);
    chk(rd == 32'hCAFEF00D, "R11 refill sees store", rd, 32'hCAFEF00D);
    w0 = u_mem1.n_wr;
    access(1, 0, 32'h030, 0, 0, rd, lat);
    access(1, 0, 32'h830, 0, 0, rd, lat);
    chk(u_mem1.n_wr == w0, "R8 no writeback when forwarding", u_mem1.n_wr, w0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      c_req[d] = 0; c_we[d] = 0; c_addr[d] = 0; c_wd[d] = 0; c_be[d] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_miss_hit();
    t_lru();
    t_write_back();
    t_write_through();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule